// File: doc/BRIEF.md
# Strided Vector Load Address Generator

This block expands one vector load into a stream of per-element memory addresses, each paired with the architectural register that receives the element. Software first binds up to two offset entries to registers with a configuration command. A bound entry adds a fixed offset amount to the base address. It can also switch the load's immediate field from an ordinary displacement into an element stride.

When a load is presented with a destination base register, an address register (number and bank), the base address held in that register, an immediate, an element width and a vector length, the block looks the address register up in the offset table. It resolves the start address and per-element step once, at acceptance. It then issues one address/register pair per cycle over a valid/ready handshake, and flags the final pair. A load whose destination run would pass the last architectural register, or whose length is zero, is refused with a one-cycle error pulse and issues nothing. The memory access and the register-file write are done by downstream logic.

Top module: `strided_load_agu`

## Requirements
- R1: After reset `req_ready` is 1, `out_valid` is 0 and `err_illegal` is 0. No offset entry is bound, so every load uses offset 0 and unit stride.
- R2: A cycle with `cfg_we`=1 writes entry `cfg_idx` (0 or 1) with register number `cfg_reg`, bank `cfg_bank` (0 integer, 1 floating point), stride mode `cfg_mode` (1 immediate-as-stride, 0 unit) and amount `cfg_amount`. A load accepted in a later cycle sees the new entry.
- R3: An entry matches a load when it is bound, its register number equals `req_areg` and its bank equals `req_abank`. The first element address is `req_base` plus the matched entry's amount. With no match it is `req_base` and the stride is unit.
- R4: When both entries match, entry 0 supplies the amount and the mode.
- R5: In immediate-as-stride mode the address step between elements is the sign-extended 12-bit `req_imm`. With immediate 12 and length 4 the addresses are start, start+12, start+24 and start+36. Negative immediates step downward.
- R6: In unit mode the step is the element size in bytes from `req_width`: code 0 gives XLEN/8, code 1 gives 1, code 2 gives 2 and code 3 gives 4.
- R7: Element i (0 to VL-1) is issued with register `req_dst`+i and address start+i*step, modulo 2^XLEN, in increasing i.
- R8: A load with `req_vl`=0 or `req_dst`+`req_vl` > 32 is accepted, raises `err_illegal` for exactly the next cycle and issues no element. `req_ready` stays 1.
- R9: Element 0 is valid the cycle after acceptance. One element retires in each cycle that has `out_valid` and `out_ready` both 1. While `out_ready` is 0 the outputs are held. `out_last` is 1 with the final element. `req_ready` is 0 from acceptance until the cycle after the final element retires.
- R10: Configuration writes made while a load is being issued do not change that load's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Offset entry write strobe |
| cfg_idx | input | 1 | Entry written |
| cfg_reg | input | 5 | Register number bound to the entry |
| cfg_bank | input | 1 | Register bank of the binding, 0 integer, 1 floating point |
| cfg_mode | input | 1 | 1 immediate-as-stride, 0 unit stride |
| cfg_amount | input | XLEN | Offset amount |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Generator idle, request accepted when both are 1 |
| req_dst | input | 5 | First destination register |
| req_areg | input | 5 | Address register number |
| req_abank | input | 1 | Address register bank |
| req_base | input | XLEN | Contents of the address register |
| req_imm | input | 12 | Load immediate |
| req_width | input | 2 | Element width code |
| req_vl | input | 6 | Vector length, 0 to 32 |
| out_valid | output | 1 | Element address valid |
| out_ready | input | 1 | Consumer takes the element |
| out_addr | output | XLEN | Element memory address |
| out_reg | output | 5 | Element destination register |
| out_last | output | 1 | Final element of the load |
| err_illegal | output | 1 | Refused-load pulse |

## Verification
The bench targets the edges of the destination range. It uses a run that ends exactly at register 31 and one that would pass it. An off-by-one legality test would either refuse a valid load or issue addresses into a wrapped register number. Double matches and bank mismatches check the table priority: a wrong priority or a lookup that ignores the bank shows up as the wrong start address or step. Random backpressure combined with configuration rewrites during a running load catches a generator that advances while stalled, or one that re-reads the table mid-load instead of using its snapshot. Negative strides check the sign extension of the immediate.

// File: rtl/sldagu_pkg.sv
package sldagu_pkg;

    typedef enum logic [1:0] {
        EW_NATIVE = 2'd0,
        EW_BYTE   = 2'd1,
        EW_HALF   = 2'd2,
        EW_WORD   = 2'd3
    } elem_width_e;

    typedef enum logic {
        STEP_UNIT = 1'b0,
        STEP_IMM  = 1'b1
    } step_mode_e;

    // Element size in bytes for the fixed codes; native width returns 0
    function automatic logic [3:0] fixed_bytes(input logic [1:0] code);
        case (code)
            EW_BYTE: fixed_bytes = 4'd1;
            EW_HALF: fixed_bytes = 4'd2;
            EW_WORD: fixed_bytes = 4'd4;
            default: fixed_bytes = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/sldagu_offset_table.sv
module sldagu_offset_table #(
    parameter int XLEN        = 32,
    parameter int REG_W       = 5,
    parameter int NUM_ENTRIES = 2,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             wr_bank,
    input  logic             wr_mode,
    input  logic [XLEN-1:0]  wr_amount,
    input  logic [REG_W-1:0] lk_reg,
    input  logic             lk_bank,
    output logic             hit,
    output logic             hit_mode,
    output logic [XLEN-1:0]  hit_amount
);

    typedef struct packed {
        logic             used;
        logic [REG_W-1:0] regn;
        logic             bank;
        logic             mode;
        logic [XLEN-1:0]  amount;
    } entry_t;

    entry_t [NUM_ENTRIES-1:0] ent_d, ent_q;
    logic   [NUM_ENTRIES-1:0] match;
    logic   [IDX_W-1:0]       sel;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx].used   = 1'b1;
            ent_d[wr_idx].regn   = wr_reg;
            ent_d[wr_idx].bank   = wr_bank;
            ent_d[wr_idx].mode   = wr_mode;
            ent_d[wr_idx].amount = wr_amount;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
        assign match[g] = ent_q[g].used && (ent_q[g].regn == lk_reg)
                          && (ent_q[g].bank == lk_bank);
    end

    // Lowest-numbered matching entry wins
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit = 1'b1;
                sel = IDX_W'(k);
            end
        end
    end

    assign hit_mode   = hit ? ent_q[sel].mode : 1'b0;
    assign hit_amount = hit ? ent_q[sel].amount : '0;

    AST_MISS_IS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_amount == '0) && !hit_mode); // R3

endmodule

// File: rtl/sldagu_step_sel.sv
module sldagu_step_sel
    import sldagu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       width,
    input  logic             mode,
    input  logic [XLEN-1:0]  amount,
    output logic [XLEN-1:0]  start_addr,
    output logic [XLEN-1:0]  step
);

    localparam int NATIVE_BYTES = XLEN / 8;

    logic [XLEN-1:0] unit_step;
    logic [XLEN-1:0] imm_step;

    always_comb begin
        if (width == EW_NATIVE) unit_step = XLEN'(NATIVE_BYTES);
        else                    unit_step = XLEN'(fixed_bytes(width));
    end

    assign imm_step   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign step       = (mode == STEP_IMM) ? imm_step : unit_step;
    assign start_addr = base + amount;

endmodule

// File: rtl/sldagu_sequencer.sv
module sldagu_sequencer #(
    parameter int XLEN   = 32,
    parameter int NREGS  = 32,
    parameter int REG_W  = 5,
    parameter int VL_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic [REG_W-1:0] dst,
    input  logic [VL_W-1:0]  vl,
    input  logic [XLEN-1:0]  start_addr,
    input  logic [XLEN-1:0]  step,
    input  logic             out_ready,
    output logic             busy,
    output logic [XLEN-1:0]  out_addr,
    output logic [REG_W-1:0] out_reg,
    output logic             out_last,
    output logic             err_out
);

    typedef struct packed {
        logic             busy;
        logic             err;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  step;
        logic [REG_W-1:0] regn;
        logic [VL_W-1:0]  left;
    } seq_t;

    seq_t state_d, state_q;

    logic [VL_W:0] run_end;
    logic          illegal;

    assign run_end = {1'b0, VL_W'(dst)} + {1'b0, vl};
    assign illegal = (vl == '0) || (run_end > (VL_W+1)'(NREGS));

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        if (!state_q.busy) begin
            if (req_fire) begin
                if (illegal) begin
                    state_d.err = 1'b1;
                end else begin
                    state_d.busy = 1'b1;
                    state_d.addr = start_addr;
                    state_d.step = step;
                    state_d.regn = dst;
                    state_d.left = vl - 1'b1;
                end
            end
        end else if (out_ready) begin
            if (state_q.left == '0) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.addr = state_q.addr + state_q.step;
                state_d.regn = state_q.regn + 1'b1;
                state_d.left = state_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy     = state_q.busy;
    assign out_addr = state_q.addr;
    assign out_reg  = state_q.regn;
    assign out_last = state_q.busy && (state_q.left == '0);
    assign err_out  = state_q.err;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !out_ready |=> busy && $stable(out_addr) && $stable(out_reg) && $stable(out_last)); // R9
    AST_REG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_ready && !out_last |=> busy && (out_reg == $past(out_reg) + 1'b1)); // R7
    AST_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_ready && !out_last |=> out_addr == $past(out_addr) + $past(state_q.step)); // R7
    AST_LAST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_ready && out_last |=> !busy); // R9
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire && illegal |=> err_out && !busy); // R8
    AST_FIRST_REG: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire && !illegal |=> busy && (out_reg == $past(dst))); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> !busy); // R8

endmodule

// File: rtl/strided_load_agu.sv
module strided_load_agu #(
    parameter int XLEN        = 32,
    parameter int NREGS       = 32,
    parameter int NUM_ENTRIES = 2,
    parameter int IMM_W       = 12,
    localparam int REG_W      = $clog2(NREGS),
    localparam int VL_W       = REG_W + 1,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_reg,
    input  logic             cfg_bank,
    input  logic             cfg_mode,
    input  logic [XLEN-1:0]  cfg_amount,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [REG_W-1:0] req_dst,
    input  logic [REG_W-1:0] req_areg,
    input  logic             req_abank,
    input  logic [XLEN-1:0]  req_base,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [1:0]       req_width,
    input  logic [VL_W-1:0]  req_vl,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [XLEN-1:0]  out_addr,
    output logic [REG_W-1:0] out_reg,
    output logic             out_last,
    output logic             err_illegal
);

    logic            busy;
    logic            req_fire;
    logic            hit;
    logic            hit_mode;
    logic [XLEN-1:0] hit_amount;
    logic [XLEN-1:0] start_addr;
    logic [XLEN-1:0] step;

    assign req_ready = !busy;
    assign req_fire  = req_valid && req_ready;
    assign out_valid = busy;

    sldagu_offset_table #(
        .XLEN        (XLEN),
        .REG_W       (REG_W),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_reg     (cfg_reg),
        .wr_bank    (cfg_bank),
        .wr_mode    (cfg_mode),
        .wr_amount  (cfg_amount),
        .lk_reg     (req_areg),
        .lk_bank    (req_abank),
        .hit        (hit),
        .hit_mode   (hit_mode),
        .hit_amount (hit_amount)
    );

    sldagu_step_sel #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_step (
        .base       (req_base),
        .imm        (req_imm),
        .width      (req_width),
        .mode       (hit_mode),
        .amount     (hit_amount),
        .start_addr (start_addr),
        .step       (step)
    );

    sldagu_sequencer #(
        .XLEN  (XLEN),
        .NREGS (NREGS),
        .REG_W (REG_W),
        .VL_W  (VL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .dst        (req_dst),
        .vl         (req_vl),
        .start_addr (start_addr),
        .step       (step),
        .out_ready  (out_ready),
        .busy       (busy),
        .out_addr   (out_addr),
        .out_reg    (out_reg),
        .out_last   (out_last),
        .err_out    (err_illegal)
    );

    AST_READY_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> req_ready); // R9
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(out_ready && out_last) |=> !req_ready); // R9
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire && !hit && (req_vl != '0) && (({1'b0, VL_W'(req_dst)} + {1'b0, req_vl}) <= (VL_W+1)'(NREGS))
        |=> out_addr == $past(req_base)); // R3

endmodule

// File: tb/strided_load_agu_tb.sv
module strided_load_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_idx = 1'b0;
    logic [4:0]  cfg_reg = '0;
    logic        cfg_bank = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [31:0] cfg_amount = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_dst = '0;
    logic [4:0]  req_areg = '0;
    logic        req_abank = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_imm = '0;
    logic [1:0]  req_width = '0;
    logic [5:0]  req_vl = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [4:0]  out_reg;
    logic        out_last;
    logic        err_illegal;

    always #2.5 clk = ~clk;

    strided_load_agu u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_reg(cfg_reg), .cfg_bank(cfg_bank),
        .cfg_mode(cfg_mode), .cfg_amount(cfg_amount),
        .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst),
        .req_areg(req_areg), .req_abank(req_abank), .req_base(req_base),
        .req_imm(req_imm), .req_width(req_width), .req_vl(req_vl),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_reg(out_reg), .out_last(out_last), .err_illegal(err_illegal)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [4:0]  rg;
        logic        last;
    } elem_t;

    int     checks = 0;
    int     errors = 0;
    string  tag = "R1";
    bit     stall_mode = 1'b0;
    bit     compare_on = 1'b0;
    int     cycles = 0;

    // Behavioural reference state
    elem_t       expq[$];
    bit          exp_err = 1'b0;
    bit          m_used [2];
    logic [4:0]  m_reg  [2];
    bit          m_bank [2];
    bit          m_mode [2];
    logic [31:0] m_amt  [2];

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            expq.delete();
            exp_err = 1'b0;
            for (int e = 0; e < 2; e++) m_used[e] = 1'b0;
        end else begin
            bit          idle;
            bit          found;
            bit          smode;
            logic [31:0] offs;
            logic [31:0] stp;
            elem_t       el;
            idle    = (expq.size() == 0);
            exp_err = 1'b0;
            if (!idle && out_ready) void'(expq.pop_front());
            if (idle && req_valid) begin
                found = 1'b0; offs = 0; smode = 1'b0;
                for (int e = 0; e < 2; e++) begin
                    if (!found && m_used[e] && m_reg[e] == req_areg && m_bank[e] == req_abank) begin
                        found = 1'b1; offs = m_amt[e]; smode = m_mode[e];
                    end
                end
                if (smode) stp = {{20{req_imm[11]}}, req_imm};
                else case (req_width)
                    2'd0: stp = 4;
                    2'd1: stp = 1;
                    2'd2: stp = 2;
                    default: stp = 4;
                endcase
                if (req_vl == 0 || int'(req_dst) + int'(req_vl) > 32) exp_err = 1'b1;
                else for (int i = 0; i < int'(req_vl); i++) begin
                    el.addr = req_base + offs + 32'(i) * stp;
                    el.rg   = 5'(int'(req_dst) + i);
                    el.last = (i == int'(req_vl) - 1);
                    expq.push_back(el);
                end
            end
            if (cfg_we) begin
                m_used[cfg_idx] = 1'b1; m_reg[cfg_idx] = cfg_reg; m_bank[cfg_idx] = cfg_bank;
                m_mode[cfg_idx] = cfg_mode; m_amt[cfg_idx] = cfg_amount;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            bit busy_m;
            busy_m = (expq.size() != 0);
            check(out_valid == busy_m, "R9 out_valid", 32'(out_valid), 32'(busy_m));
            check(req_ready == !busy_m, "R9 req_ready", 32'(req_ready), 32'(!busy_m));
            check(err_illegal == exp_err, "R8 err_illegal", 32'(err_illegal), 32'(exp_err));
            if (busy_m && out_valid) begin
                check(out_addr == expq[0].addr, "R7 out_addr", out_addr, expq[0].addr);
                check(out_reg == expq[0].rg, "R7 out_reg", 32'(out_reg), 32'(expq[0].rg));
                check(out_last == expq[0].last, "R9 out_last", 32'(out_last), 32'(expq[0].last));
            end
        end
        out_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cfg_write(input bit idx, input logic [4:0] rg, input bit bank, input bit mode, input logic [31:0] amt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_reg = rg; cfg_bank = bank; cfg_mode = mode; cfg_amount = amt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [4:0] dst, input logic [4:0] areg, input bit bank,
                         input logic [31:0] base, input logic [11:0] imm, input logic [1:0] w, input logic [5:0] vl);
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_dst = dst; req_areg = areg; req_abank = bank;
        req_base = base; req_imm = imm; req_width = w; req_vl = vl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 1);
        check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
        check(err_illegal == 1'b0, "R1 reset err", 32'(err_illegal), 0);
        compare_on = 1'b1;
        issue(5'd8, 5'd5, 1'b0, 32'h1000, 12'd12, 2'd0, 6'd4);
        wait_idle();

        tag = "R6";
        issue(5'd1, 5'd5, 1'b0, 32'h2000, 12'd0, 2'd1, 6'd3);
        issue(5'd1, 5'd5, 1'b0, 32'h2000, 12'd0, 2'd2, 6'd3);
        issue(5'd1, 5'd5, 1'b0, 32'h2000, 12'd0, 2'd3, 6'd3);
        wait_idle();

        tag = "R5";
        cfg_write(1'b0, 5'd7, 1'b0, 1'b1, 32'h0);
        issue(5'd3, 5'd7, 1'b0, 32'h3000, 12'd12, 2'd0, 6'd4);
        issue(5'd3, 5'd7, 1'b0, 32'h3000, 12'hFF8, 2'd0, 6'd5);
        wait_idle();

        tag = "R2";
        cfg_write(1'b1, 5'd9, 1'b0, 1'b0, 32'h40);
        tag = "R3";
        issue(5'd10, 5'd9, 1'b0, 32'h4000, 12'd100, 2'd0, 6'd3);
        issue(5'd10, 5'd9, 1'b1, 32'h4000, 12'd100, 2'd0, 6'd3);
        issue(5'd10, 5'd7, 1'b1, 32'h4000, 12'd100, 2'd2, 6'd2);
        wait_idle();

        tag = "R4";
        cfg_write(1'b0, 5'd9, 1'b1, 1'b1, 32'h100);
        cfg_write(1'b1, 5'd9, 1'b1, 1'b0, 32'h200);
        issue(5'd0, 5'd9, 1'b1, 32'h5000, 12'd16, 2'd0, 6'd4);
        wait_idle();

        tag = "R8";
        issue(5'd30, 5'd1, 1'b0, 32'h6000, 12'd0, 2'd0, 6'd3);
        issue(5'd4, 5'd1, 1'b0, 32'h6000, 12'd0, 2'd0, 6'd0);
        issue(5'd28, 5'd1, 1'b0, 32'h6000, 12'd0, 2'd0, 6'd4);
        issue(5'd0, 5'd1, 1'b0, 32'h6000, 12'd0, 2'd0, 6'd33);
        wait_idle();

        tag = "R9";
        stall_mode = 1'b1;
        issue(5'd12, 5'd9, 1'b1, 32'h7000, 12'd8, 2'd0, 6'd8);
        issue(5'd20, 5'd2, 1'b0, 32'hFFFF_FFF8, 12'd0, 2'd0, 6'd6);
        wait_idle();

        tag = "R10";
        issue(5'd16, 5'd9, 1'b1, 32'h8000, 12'd20, 2'd0, 6'd10);
        cfg_write(1'b0, 5'd9, 1'b1, 1'b0, 32'h999);
        cfg_write(1'b1, 5'd9, 1'b1, 1'b1, 32'h777);
        wait_idle();
        issue(5'd16, 5'd9, 1'b1, 32'h8000, 12'd20, 2'd0, 6'd3);
        wait_idle();

        tag = "R7";
        stall_mode = 1'b0;
        issue(5'd0, 5'd3, 1'b0, 32'h9000, 12'd0, 2'd3, 6'd32);
        issue(5'd31, 5'd7, 1'b0, 32'hA000, 12'd4, 2'd0, 6'd1);
        wait_idle();
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule